// File: doc/BRIEF.md
# Nonvolatile SRAM Command Sequence Controller

This block sits in front of an SRAM array that has a nonvolatile shadow copy. It watches the bus for read cycles controlled by chip enable. A read cycle is an enable falling edge while write enable is high. The block looks for a fixed unlock pattern of five addresses. A sixth read then picks the command: one address starts a STORE, which copies the SRAM into the nonvolatile cells. Another address starts a RECALL, which clears the SRAM and then copies the nonvolatile data back into it.

While an operation runs, the port is disabled for a cycle count set by a parameter. The block also drives a write-permit signal. Writes are blocked during low supply and while an operation runs. They are also blocked when enable and write enable are both low at power-up or at the end of an operation. In that case the block waits for a fresh falling edge on either line before it permits writes again. The enable and write-enable inputs are synchronized inside the block. Each bus cycle is therefore seen exactly once.

Top module: `nvs_cmd_ctrl`

## Requirements
- R1: Reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0, in that order, produce exactly one `store_pulse`, and no recall strobe.
- R2: The same five-read prefix followed by a read at 0x0C63 produces one `clear_pulse` and, exactly CLEAR_CYC cycles later, one `recall_pulse`; `store_pulse` stays low.
- R3: A cycle in which enable falls while write enable is low never counts as a step, and it returns the detector to idle, so the remaining reads of the pattern do not launch anything.
- R4: A read at any address other than the expected one restarts the detector; if that address is 0x0E38 it counts as the first step of a new attempt.
- R5: `busy` is high for exactly STORE_CYC cycles after a STORE and RECALL_CYC cycles after a RECALL, and bus cycles seen while `busy` is high do not advance the detector.
- R6: `wr_permit` is low whenever `busy` is high.
- R7: While `low_vdd` is high, `wr_permit` is low and a completed STORE pattern launches nothing; a RECALL pattern still launches.
- R8: If `ce_n` and `we_n` are both low when an operation ends, `wr_permit` stays low until a falling edge on either line; a rising edge does not clear it. If they are not both low, `wr_permit` returns high when `busy` drops.
- R9: If `ce_n` and `we_n` are both low during reset, `wr_permit` stays low after reset until a falling edge on either line.
- R10: After reset with `ce_n` and `we_n` high, `busy` and all strobes are low and `wr_permit` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| addr | input | AW | Bus address, held for the whole enable-low period |
| ce_n | input | 1 | Chip enable, active low, asynchronous to clk |
| we_n | input | 1 | Write enable, active low, asynchronous to clk |
| low_vdd | input | 1 | High while supply is below the switch threshold |
| store_pulse | output | 1 | One-cycle strobe: begin SRAM to nonvolatile copy |
| clear_pulse | output | 1 | One-cycle strobe: RECALL phase one, clear the SRAM |
| recall_pulse | output | 1 | One-cycle strobe: RECALL phase two, load nonvolatile data |
| busy | output | 1 | Port disabled while an operation runs |
| wr_permit | output | 1 | High when an external write may reach the array |

## Verification
The hardest state to reach is the write lockout at the end of an operation. The bench has to leave both enable and write enable low while `busy` is high. That bus cycle is a write, and the detector must ignore it because the port is busy. The bench holds that level until the counter expires. It then toggles only write enable: first a rising edge, which must not release the lock, and then a falling edge, which must. The power-up variant holds both lines low through reset. This way the synchronizers load those levels without seeing a false edge.

// File: rtl/nvs_pkg.sv
// Shared types and constants for the command sequence controller.
// Assumes bus addresses are at most 16 bits wide.
package nvs_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_STORE  = 2'd1,
        OP_RECALL = 2'd2
    } op_e;

    localparam int          PREFIX_LEN  = 5;
    localparam logic [15:0] CMD_STORE   = 16'h0FC0;
    localparam logic [15:0] CMD_RECALL  = 16'h0C63;

    // Expected address for unlock step idx (0-based); order is behaviour.
    function automatic logic [15:0] prefix_addr(input logic [2:0] idx);
        case (idx)
            3'd0:    return 16'h0E38;
            3'd1:    return 16'h31C7;
            3'd2:    return 16'h03E0;
            3'd3:    return 16'h3C1F;
            3'd4:    return 16'h303F;
            default: return 16'hFFFF;
        endcase
    endfunction

endpackage

// File: rtl/nvs_bus_sampler.sv
// Synchronizes the asynchronous enable and write-enable lines and detects
// their falling edges. The address is delayed by the same number of stages,
// so the address reported with an event is the one present while enable fell.
// Assumes the address is stable while enable is low.
// During reset the synchronizers load the live pin levels, so leaving reset
// never creates a false edge.
module nvs_bus_sampler #(
    parameter int AW          = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          we_n,
    output logic          rd_evt,
    output logic          wr_evt,
    output logic [AW-1:0] evt_addr,
    output logic          e_fall,
    output logic          w_fall,
    output logic          e_low,
    output logic          w_low
);
    localparam int TOP = SYNC_STAGES;

    logic [TOP:0]  e_pipe;
    logic [TOP:0]  w_pipe;
    logic [AW-1:0] a_pipe [SYNC_STAGES];
    logic          e_now, e_prev, w_now, w_prev;

    // Shift the control lines through the synchronizer and edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_pipe <= {(TOP+1){ce_n}};
            w_pipe <= {(TOP+1){we_n}};
        end else begin
            e_pipe <= {e_pipe[TOP-1:0], ce_n};
            w_pipe <= {w_pipe[TOP-1:0], we_n};
        end
    end

    // Delay the address in step with the synchronized enable.
    always_ff @(posedge clk) begin
        a_pipe[0] <= addr;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            a_pipe[i] <= a_pipe[i-1];
        end
    end

    // Classify edges into read and write bus cycles.
    always_comb begin
        e_now    = e_pipe[TOP-1];
        e_prev   = e_pipe[TOP];
        w_now    = w_pipe[TOP-1];
        w_prev   = w_pipe[TOP];
        e_fall   = e_prev & ~e_now;
        w_fall   = w_prev & ~w_now;
        rd_evt   = e_fall & w_now;
        wr_evt   = e_fall & ~w_now;
        evt_addr = a_pipe[SYNC_STAGES-1];
        e_low    = ~e_now;
        w_low    = ~w_now;
    end

endmodule

// File: rtl/nvs_unlock_fsm.sv
// Tracks the six-step read-only unlock pattern and issues a one-cycle start
// request for STORE or RECALL. Write cycles return it to idle. A mismatching
// read restarts it, counting as step one when it is the first prefix address.
// It ignores all bus cycles while an operation is busy. Under low supply a
// STORE request is dropped and the pattern is discarded.
module nvs_unlock_fsm #(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_evt,
    input  logic          wr_evt,
    input  logic [AW-1:0] evt_addr,
    input  logic          busy,
    input  logic          low_vdd,
    output logic          start_store,
    output logic          start_recall
);
    import nvs_pkg::*;

    localparam logic [2:0] LAST_STEP = 3'(PREFIX_LEN);

    logic [2:0]  step, step_nx;
    logic        go_store, go_recall;
    logic [15:0] a16;

    // Next step and launch decision for the current bus event.
    always_comb begin
        a16       = 16'(evt_addr);
        step_nx   = step;
        go_store  = 1'b0;
        go_recall = 1'b0;
        if (!busy) begin
            if (wr_evt) begin
                step_nx = '0;
            end else if (rd_evt) begin
                if (step < LAST_STEP && a16 == prefix_addr(step)) begin
                    step_nx = step + 3'd1;
                end else if (step == LAST_STEP && a16 == CMD_STORE) begin
                    step_nx  = '0;
                    go_store = ~low_vdd;
                end else if (step == LAST_STEP && a16 == CMD_RECALL) begin
                    step_nx   = '0;
                    go_recall = 1'b1;
                end else begin
                    step_nx = (a16 == prefix_addr(3'd0)) ? 3'd1 : 3'd0;
                end
            end
        end
    end

    // Register the step count and the start requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step         <= '0;
            start_store  <= 1'b0;
            start_recall <= 1'b0;
        end else begin
            step         <= step_nx;
            start_store  <= go_store;
            start_recall <= go_recall;
        end
    end

    // R3: a write cycle seen while idle-capable leaves no progress and no launch.
    a_r3_write_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && !busy) |=> (step == 3'd0 && !start_store && !start_recall));

    // R1: the two start requests are never raised together.
    a_r1_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_store && start_recall));

endmodule

// File: rtl/nvs_op_timer.sv
// Runs one STORE or RECALL operation. On a start request it raises busy for
// the operation's cycle count. STORE emits one strobe at the start. RECALL
// emits a clear strobe at the start and a load strobe CLEAR_CYC cycles later.
// op_done marks the last busy cycle. Assumes CLEAR_CYC < RECALL_CYC and that
// starts arrive only while idle.
module nvs_op_timer #(
    parameter int STORE_CYC  = 2000,
    parameter int RECALL_CYC = 1000,
    parameter int CLEAR_CYC  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_store,
    input  logic start_recall,
    output logic busy,
    output logic store_pulse,
    output logic clear_pulse,
    output logic recall_pulse,
    output logic op_done
);
    import nvs_pkg::*;

    localparam int            MAXC       = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int            CW         = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LAST_STORE = CW'(STORE_CYC - 1);
    localparam logic [CW-1:0] LAST_RECAL = CW'(RECALL_CYC - 1);
    localparam logic [CW-1:0] CLEAR_END  = CW'(CLEAR_CYC - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_cnt;
    op_e           kind;

    // Final count value for the running operation, and end-of-operation flag.
    always_comb begin
        last_cnt = (kind == OP_STORE) ? LAST_STORE : LAST_RECAL;
        op_done  = busy && (cnt == last_cnt);
    end

    // Launch, count and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            cnt          <= '0;
            kind         <= OP_NONE;
            store_pulse  <= 1'b0;
            clear_pulse  <= 1'b0;
            recall_pulse <= 1'b0;
        end else begin
            store_pulse  <= 1'b0;
            clear_pulse  <= 1'b0;
            recall_pulse <= 1'b0;
            if (!busy && (start_store || start_recall)) begin
                busy        <= 1'b1;
                cnt         <= '0;
                kind        <= start_store ? OP_STORE : OP_RECALL;
                store_pulse <= start_store;
                clear_pulse <= start_recall;
            end else if (busy) begin
                recall_pulse <= (kind == OP_RECALL) && (cnt == CLEAR_END);
                if (op_done) begin
                    busy <= 1'b0;
                    kind <= OP_NONE;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2: the load phase only happens inside a running RECALL.
    a_r2_load_in_recall: assert property (@(posedge clk) disable iff (!rst_n)
        recall_pulse |-> (busy && kind == OP_RECALL));

    // R5: no new start request reaches the timer while it is busy.
    a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(start_store || start_recall));

    // R1: a store strobe lasts one cycle.
    a_r1_store_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        store_pulse |=> !store_pulse);

endmodule

// File: rtl/nvs_write_guard.sv
// Decides whether an external write may reach the array. Writes are blocked
// under low supply and while busy. A lock is also set when enable and write
// enable are both low at reset or on the last busy cycle. The lock clears on
// the next synchronized falling edge of either line.
module nvs_write_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic e_low,
    input  logic w_low,
    input  logic e_fall,
    input  logic w_fall,
    input  logic op_done,
    input  logic busy,
    input  logic low_vdd,
    output logic wr_permit
);
    logic lock;

    // Maintain the write lockout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock <= ~ce_n & ~we_n;
        end else if (op_done) begin
            lock <= e_low & w_low;
        end else if (e_fall || w_fall) begin
            lock <= 1'b0;
        end
    end

    // Combine all write-blocking conditions.
    always_comb begin
        wr_permit = ~low_vdd & ~busy & ~lock;
    end

    // R8: with neither line falling and no operation ending, a held lock persists.
    a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !e_fall && !w_fall && !op_done) |=> lock);

endmodule

// File: rtl/nvs_cmd_ctrl.sv
// Top of the command sequence controller: bus sampler, unlock detector,
// operation timer and write guard. Assumes AW is between 14 and 16 and that
// the address is stable while ce_n is low.
module nvs_cmd_ctrl #(
    parameter int AW          = 14,
    parameter int SYNC_STAGES = 2,
    parameter int STORE_CYC   = 2000,
    parameter int RECALL_CYC  = 1000,
    parameter int CLEAR_CYC   = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          low_vdd,
    output logic          store_pulse,
    output logic          clear_pulse,
    output logic          recall_pulse,
    output logic          busy,
    output logic          wr_permit
);
    logic          rd_evt, wr_evt, e_fall, w_fall, e_low, w_low;
    logic [AW-1:0] evt_addr;
    logic          start_store, start_recall, op_done;

    nvs_bus_sampler #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
        .rd_evt(rd_evt), .wr_evt(wr_evt), .evt_addr(evt_addr),
        .e_fall(e_fall), .w_fall(w_fall), .e_low(e_low), .w_low(w_low)
    );

    nvs_unlock_fsm #(.AW(AW)) u_unlock (
        .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .wr_evt(wr_evt),
        .evt_addr(evt_addr), .busy(busy), .low_vdd(low_vdd),
        .start_store(start_store), .start_recall(start_recall)
    );

    nvs_op_timer #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC),
                   .CLEAR_CYC(CLEAR_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_store(start_store),
        .start_recall(start_recall), .busy(busy), .store_pulse(store_pulse),
        .clear_pulse(clear_pulse), .recall_pulse(recall_pulse), .op_done(op_done)
    );

    nvs_write_guard u_guard (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .e_low(e_low), .w_low(w_low), .e_fall(e_fall), .w_fall(w_fall),
        .op_done(op_done), .busy(busy), .low_vdd(low_vdd), .wr_permit(wr_permit)
    );

    // R6: the port never permits writes during an operation.
    a_r6_busy_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_permit);

    // R7: a STORE never starts from a pattern completed under low supply.
    a_r7_no_store_low: assert property (@(posedge clk) disable iff (!rst_n)
        store_pulse |-> !$past(low_vdd, 2));

endmodule

// File: tb/tb_nvs_cmd_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_nvs_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int T_ST = 80;
    localparam int T_RC = 90;
    localparam int T_CL = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] addr = '0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        low_vdd = 1'b0;
    logic        store_pulse, clear_pulse, recall_pulse, busy, wr_permit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_store = 0, n_clear = 0, n_recall = 0, n_busy = 0;
    int clear_at = 0, recall_at = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvs_cmd_ctrl #(.AW(14), .SYNC_STAGES(2), .STORE_CYC(T_ST),
                   .RECALL_CYC(T_RC), .CLEAR_CYC(T_CL)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
        .low_vdd(low_vdd), .store_pulse(store_pulse), .clear_pulse(clear_pulse),
        .recall_pulse(recall_pulse), .busy(busy), .wr_permit(wr_permit)
    );

    // Count strobes and busy cycles away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (store_pulse) n_store++;
        if (clear_pulse) begin n_clear++; clear_at = cyc; end
        if (recall_pulse) begin n_recall++; recall_at = cyc; end
        if (busy) n_busy++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk); addr = a[13:0]; ce_n = 1'b1; we_n = 1'b1;
        repeat (3) @(negedge clk);
        ce_n = 1'b0;
        repeat (4) @(negedge clk);
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a);
        @(negedge clk); addr = a[13:0]; ce_n = 1'b1; we_n = 1'b0;
        repeat (3) @(negedge clk);
        ce_n = 1'b0;
        repeat (4) @(negedge clk);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic prefix(input int n);
        logic [15:0] p [5] = '{16'h0E38, 16'h31C7, 16'h03E0, 16'h3C1F, 16'h303F};
        for (int i = 0; i < n; i++) rd(p[i]);
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 1000) begin @(negedge clk); g++; end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R10 busy after reset", busy, 0);
        chk("R10 strobes after reset", n_store + n_clear + n_recall, 0);
        chk("R10 wr_permit after reset", wr_permit, 1);
    endtask

    task automatic t_store();
        int s0 = n_store, r0 = n_recall, b0 = n_busy;
        prefix(5); rd(16'h0FC0);
        chk("R6 busy during store", busy, 1);
        chk("R6 wr_permit during store", wr_permit, 0);
        wait_idle();
        chk("R1 one store strobe", n_store - s0, 1);
        chk("R1 no recall strobe", n_recall - r0, 0);
        chk("R5 store busy length", n_busy - b0, T_ST);
        chk("R8 permit returns without lock", wr_permit, 1);
    endtask

    task automatic t_recall();
        int s0 = n_store, c0 = n_clear, r0 = n_recall, b0 = n_busy;
        prefix(5); rd(16'h0C63);
        wait_idle();
        chk("R2 one clear strobe", n_clear - c0, 1);
        chk("R2 one load strobe", n_recall - r0, 1);
        chk("R2 clear to load gap", recall_at - clear_at, T_CL);
        chk("R2 no store strobe", n_store - s0, 0);
        chk("R5 recall busy length", n_busy - b0, T_RC);
    endtask

    task automatic t_write_mid();
        int s0 = n_store, b0 = n_busy;
        prefix(3); wr(16'h3C1F); rd(16'h3C1F); rd(16'h303F); rd(16'h0FC0);
        wait_idle();
        chk("R3 write mid-sequence idles", n_store - s0, 0);
        prefix(5); wr(16'h0FC0); rd(16'h0FC0);
        wait_idle();
        chk("R3 write as sixth step ignored", n_store - s0, 0);
        chk("R3 no busy after write", n_busy - b0, 0);
    endtask

    task automatic t_restart();
        int s0 = n_store;
        rd(16'h0E38); rd(16'h31C7); rd(16'h0E38);
        rd(16'h31C7); rd(16'h03E0); rd(16'h3C1F); rd(16'h303F); rd(16'h0FC0);
        wait_idle();
        chk("R4 first address restarts at step one", n_store - s0, 1);
        s0 = n_store;
        prefix(5); rd(16'h1234); rd(16'h0FC0);
        wait_idle();
        chk("R4 wrong sixth address resets", n_store - s0, 0);
    endtask

    task automatic t_busy_ignore();
        int s0;
        prefix(5); rd(16'h0FC0);
        rd(16'h0E38);
        chk("R5 still busy during extra read", busy, 1);
        wait_idle();
        s0 = n_store;
        rd(16'h31C7); rd(16'h03E0); rd(16'h3C1F); rd(16'h303F); rd(16'h0FC0);
        wait_idle();
        chk("R5 read during busy not counted", n_store - s0, 0);
    endtask

    task automatic t_lowv();
        int s0 = n_store, r0 = n_recall, b0 = n_busy;
        low_vdd = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 wr_permit low under low supply", wr_permit, 0);
        prefix(5); rd(16'h0FC0);
        wait_idle();
        chk("R7 store blocked", n_store - s0, 0);
        chk("R7 no busy from blocked store", n_busy - b0, 0);
        prefix(5); rd(16'h0C63);
        wait_idle();
        chk("R7 recall allowed", n_recall - r0, 1);
        low_vdd = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_lock_end();
        prefix(5); rd(16'h0FC0);
        we_n = 1'b0; repeat (3) @(negedge clk);
        ce_n = 1'b0;
        wait_idle();
        chk("R8 lock after op with both low", wr_permit, 0);
        we_n = 1'b1; repeat (5) @(negedge clk);
        chk("R8 rising edge keeps lock", wr_permit, 0);
        we_n = 1'b0; repeat (5) @(negedge clk);
        chk("R8 falling edge clears lock", wr_permit, 1);
        ce_n = 1'b1; we_n = 1'b1; repeat (4) @(negedge clk);
    endtask

    task automatic t_lock_power();
        @(negedge clk); rst_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1; repeat (5) @(negedge clk);
        chk("R9 lock after power-up write mode", wr_permit, 0);
        ce_n = 1'b1; repeat (5) @(negedge clk);
        chk("R9 rising enable keeps lock", wr_permit, 0);
        ce_n = 1'b0; repeat (5) @(negedge clk);
        chk("R9 falling enable clears lock", wr_permit, 1);
        ce_n = 1'b1; we_n = 1'b1; repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_store();
        t_recall();
        t_write_mid();
        t_restart();
        t_busy_ignore();
        t_lowv();
        t_lock_end();
        t_lock_power();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule